// File: doc/BRIEF.md
# Keyed configuration register port

This block gives a host a way to program the configuration of a multi-function peripheral over a byte-wide bus. It has two byte locations. Offset 0 is the index port and offset 1 is the data port. After reset the port is locked. While it is locked, reads from either location return 0xFF and writes to the data port have no effect. To unlock the port, the host writes the entry key 0x87 to the index port twice in a row. Once the port is open, a byte written to the index port selects a register, and the data port then reads or writes that register. Writing 0xAA to the index port locks the port again. Register contents and device activation are kept across the lock.

Indices below 0x30 form the global range. Index 0x07 holds the logical-device selector. Bit 6 of index 0x26 allows writes to all the other registers. Indices from 0x30 upward are banked, so each logical device has its own copy and the selector picks which copy is visible. In every bank:
- Index 0x30 bit 0 activates that device. The block drives one activate output per device.
- Base addresses are stored high byte first: the high byte at an even index from 0x60 and the low byte at the next index.
- Index 0x70 holds the interrupt number and 0x71 holds its type. Type 0x02 means active-high, edge-triggered.
- A window at 0xF0 holds device-specific settings.

Read data returns as a one-beat response with a valid flag, and there is no ready signal. The host must take `bus_rdata` in the cycle that `bus_rvalid` is high. No new request waits on the host, so there is no back-pressure to apply.

Top module: `cfgport_top`

## Requirements
- R1: After reset the port is locked (`cfg_unlocked`=0), all `dev_active` bits are 0, the latched index is 0x00, the selector is 0x00 and every stored register is 0x00.
- R2: Two consecutive bus writes of 0x87 to offset 0 set `cfg_unlocked` to 1 in the cycle after the second write.
- R3: While the port is locked, any bus write between the two key bytes restarts key matching. This covers a write to offset 0 of any value other than 0x87, and any write to offset 1. The port stays locked until 0x87 is written twice more in a row.
- R4: While the port is locked, writes to offset 1 change no register, and reads of either offset return 0xFF.
- R5: While the port is unlocked, a write of 0xAA to offset 0 locks it in the next cycle and does not change the latched index. All registers and `dev_active` keep their values.
- R6: While the port is unlocked, any other write to offset 0 latches that byte as the index, and a read of offset 0 returns the latched index.
- R7: While bit 6 of global register 0x26 is 0, data writes to every register except 0x26 are ignored. While the bit is 1, data writes to all registers are accepted.
- R8: Register 0x07 reads back the full written byte. Selector values 0 to NDEV-1 make that device's bank visible at indices 0x30 and above, and each bank keeps its own values.
- R9: Writing index 0x30 sets the selected device's `dev_active` bit to bit 0 of the written byte in the next cycle. Index 0x30 reads back as 0x00 or 0x01.
- R10: In each bank, indices 0x60..0x67, 0x70..0x77 and 0xF0..0xF7 store bytes and read them back. Global indices 0x20..0x2F also store bytes. All other indices read 0x00 and ignore writes.
- R11: While the selector is NDEV or above, banked writes are ignored and banked reads return 0x00.
- R12: A read strobe without a write strobe raises `bus_rvalid` for exactly one cycle, in the next cycle. `bus_rdata` is valid in that cycle. `bus_rvalid` is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read; ignored when `bus_wr` is also high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read response data |
| bus_rvalid | output | 1 | Read response valid, one cycle after `bus_rd` |
| cfg_unlocked | output | 1 | Configuration access is open |
| dev_active | output | NDEV | Activate bit of each logical device |

## Verification
A fault in the unlock state machine shows up at the next read strobe. One cycle after that strobe, `bus_rdata` carries 0xFF where stored data was expected, or stored data where 0xFF was expected. `cfg_unlocked` also moves in the cycle after the key or exit write that caused the fault. A wrong selector or a wrong bank slot decode shows up in two ways. Readback after a bank switch returns another device's byte or 0x00. A `dev_active` bit other than the selected one changes in the cycle after a write to 0x30. For this reason the bench writes different values to several devices and reads them back after switching banks.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  typedef enum logic [1:0] {
    ST_LOCKED = 2'd0,
    ST_KEY1   = 2'd1,
    ST_OPEN   = 2'd2
  } lock_state_t;

  localparam logic [7:0] KEY_BYTE  = 8'h87;
  localparam logic [7:0] EXIT_BYTE = 8'hAA;
  localparam logic [7:0] IDX_SEL   = 8'h07;
  localparam logic [7:0] IDX_GATE  = 8'h26;
  localparam logic [7:0] IDX_ACT   = 8'h30;
  localparam logic [7:0] GLOB_LO   = 8'h20;
  localparam int         GATE_BIT  = 6;

  // Map a banked index to a storage slot, or -1 when the index has no storage.
  function automatic int slot_of(input logic [7:0] idx, input int grp);
    int o;
    o = int'(idx);
    if (o >= 'h60 && o < 'h60 + grp) return o - 'h60;
    if (o >= 'h70 && o < 'h70 + grp) return grp + o - 'h70;
    if (o >= 'hF0 && o < 'hF0 + grp) return 2 * grp + o - 'hF0;
    return -1;
  endfunction

endpackage

// File: rtl/cfgport_unlock.sv
module cfgport_unlock
  import cfgport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic       open,
  output logic [7:0] idx
);

  lock_state_t st;
  logic        idx_hit;
  assign idx_hit = wr && !addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_LOCKED;
      idx <= 8'h00;
    end else if (wr) begin
      case (st)
        ST_LOCKED: if (idx_hit && wdata == KEY_BYTE) st <= ST_KEY1;
        ST_KEY1:   st <= (idx_hit && wdata == KEY_BYTE) ? ST_OPEN : ST_LOCKED;
        ST_OPEN: begin
          if (idx_hit) begin
            if (wdata == EXIT_BYTE) st <= ST_LOCKED;
            else                    idx <= wdata;
          end
        end
        default: st <= ST_LOCKED;
      endcase
    end
  end

  assign open = (st == ST_OPEN);

endmodule

// File: rtl/cfgport_global.sv
module cfgport_global
  import cfgport_pkg::*;
#(
  parameter int NGLOB = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] idx,
  input  logic [7:0] wdata,
  output logic [7:0] rd,
  output logic [7:0] sel,
  output logic       rw_en
);

  localparam int GW = $clog2(NGLOB);

  logic [7:0] greg [NGLOB];
  logic       in_win;
  logic [GW-1:0] gofs;
  logic [7:0] diff;

  assign diff   = idx - GLOB_LO;
  assign in_win = (idx >= GLOB_LO) && (int'(diff) < NGLOB);
  assign gofs   = diff[GW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel <= 8'h00;
      for (int i = 0; i < NGLOB; i++) greg[i] <= 8'h00;
    end else if (we) begin
      if (idx == IDX_SEL) sel <= wdata;
      else if (in_win)    greg[gofs] <= wdata;
    end
  end

  localparam logic [7:0] GATE_OFS = IDX_GATE - GLOB_LO;
  assign rw_en = greg[GATE_OFS[GW-1:0]][GATE_BIT];

  always_comb begin
    if (idx == IDX_SEL) rd = sel;
    else if (in_win)    rd = greg[gofs];
    else                rd = 8'h00;
  end

endmodule

// File: rtl/cfgport_bank.sv
module cfgport_bank
  import cfgport_pkg::*;
#(
  parameter int NDEV = 4,
  parameter int GRP  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [7:0]      idx,
  input  logic [7:0]      wdata,
  input  logic [7:0]      sel,
  output logic [7:0]      rd,
  output logic [NDEV-1:0] active
);

  localparam int NSLOT  = 3 * GRP;
  localparam int SLOT_W = $clog2(NSLOT);
  localparam int SEL_W  = (NDEV > 1) ? $clog2(NDEV) : 1;

  logic              slot_hit;
  logic [SLOT_W-1:0] slot;
  logic              sel_ok;
  logic [SEL_W-1:0]  sel_lo;
  logic [7:0]        rd_dev [NDEV];

  always_comb begin
    int t;
    t        = slot_of(idx, GRP);
    slot_hit = (t >= 0);
    slot     = SLOT_W'(slot_hit ? t : 0);
  end

  assign sel_ok = (int'(sel) < NDEV);
  assign sel_lo = sel[SEL_W-1:0];

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    logic [7:0] mem [NSLOT];
    logic       act;
    logic       mine;
    assign mine = we && sel_ok && (int'(sel_lo) == d);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act <= 1'b0;
        for (int i = 0; i < NSLOT; i++) mem[i] <= 8'h00;
      end else if (mine) begin
        if (idx == IDX_ACT) act <= wdata[0];
        else if (slot_hit)  mem[slot] <= wdata;
      end
    end

    assign active[d] = act;
    assign rd_dev[d] = (idx == IDX_ACT) ? {7'b0, act} :
                       slot_hit         ? mem[slot]   : 8'h00;
  end

  assign rd = sel_ok ? rd_dev[sel_lo] : 8'h00;

endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
  import cfgport_pkg::*;
#(
  parameter int NDEV  = 4,
  parameter int GRP   = 8,
  parameter int NGLOB = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  output logic            bus_rvalid,
  output logic            cfg_unlocked,
  output logic [NDEV-1:0] dev_active
);

  logic       open;
  logic [7:0] idx;
  logic [7:0] glob_rd, bank_rd, sel;
  logic       rw_en, data_we, glob_we, bank_we, is_glob;
  logic [7:0] rd_next;

  cfgport_unlock u_unlock (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .open(open), .idx(idx)
  );

  assign is_glob = (idx < IDX_ACT);
  assign data_we = open && bus_wr && bus_addr && (rw_en || idx == IDX_GATE);
  assign glob_we = data_we && is_glob;
  assign bank_we = data_we && !is_glob;

  cfgport_global #(.NGLOB(NGLOB)) u_global (
    .clk(clk), .rst_n(rst_n), .we(glob_we), .idx(idx), .wdata(bus_wdata),
    .rd(glob_rd), .sel(sel), .rw_en(rw_en)
  );

  cfgport_bank #(.NDEV(NDEV), .GRP(GRP)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(bank_we), .idx(idx), .wdata(bus_wdata),
    .sel(sel), .rd(bank_rd), .active(dev_active)
  );

  always_comb begin
    if (!open)          rd_next = 8'hFF;
    else if (!bus_addr) rd_next = idx;
    else if (is_glob)   rd_next = glob_rd;
    else                rd_next = bank_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= 8'h00;
    end else begin
      bus_rvalid <= bus_rd && !bus_wr;
      if (bus_rd && !bus_wr) bus_rdata <= rd_next;
    end
  end

  assign cfg_unlocked = open;

endmodule

// File: rtl/cfgport_chk.sv
module cfgport_chk #(
  parameter int NDEV = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_addr,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [7:0]      bus_wdata,
  input logic [7:0]      bus_rdata,
  input logic            bus_rvalid,
  input logic            cfg_unlocked,
  input logic [NDEV-1:0] dev_active
);

  // R2: opening only follows a key byte on the index port
  a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_unlocked) |-> $past(bus_wr && !bus_addr && bus_wdata == 8'h87));

  // R4: locked reads return all ones
  a_r4_locked_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && !cfg_unlocked) |=> (bus_rdata == 8'hFF));

  // R5: exit byte closes the port
  a_r5_exit_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_unlocked && bus_wr && !bus_addr && bus_wdata == 8'hAA) |=> !cfg_unlocked);

  // R9: activate bits only move on an unlocked data write, at most one at a time
  a_r9_active_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_unlocked && bus_wr && bus_addr) |=> $stable(dev_active));

  a_r9_one_bit_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_unlocked && bus_wr && bus_addr) |=> $onehot0(dev_active ^ $past(dev_active)));

  // R12: one response beat per read strobe
  a_r12_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr) |=> bus_rvalid);

  a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && !bus_wr) |=> !bus_rvalid);

endmodule

bind cfgport_top cfgport_chk #(.NDEV(NDEV)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_rvalid(bus_rvalid), .cfg_unlocked(cfg_unlocked), .dev_active(dev_active)
);

// File: tb/cfgport_top_tb.sv
module cfgport_top_tb;
  localparam int NDEV = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            bus_addr = 1'b0;
  logic            bus_wr = 1'b0;
  logic            bus_rd = 1'b0;
  logic [7:0]      bus_wdata = 8'h00;
  logic [7:0]      bus_rdata;
  logic            bus_rvalid;
  logic            cfg_unlocked;
  logic [NDEV-1:0] dev_active;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_q [$];
  string      tag_q [$];
  bit         done = 0;

  always #4 clk = ~clk;

  cfgport_top #(.NDEV(NDEV)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .cfg_unlocked(cfg_unlocked), .dev_active(dev_active)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic setreg(input logic [7:0] i, input logic [7:0] d);
    wr(1'b0, i);
    wr(1'b1, d);
  endtask

  task automatic getreg(input logic [7:0] i, input logic [7:0] exp, input string tag);
    wr(1'b0, i);
    rd(1'b1, exp, tag);
  endtask

  // monitor: pops one expected byte per response beat (R12)
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        chk(1, 0, "R12 response without request");
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(bus_rdata, e, t);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cfg_unlocked, 0, "R1 locked after reset");
    chk(dev_active, 0, "R1 activate cleared");
    chk(bus_rvalid, 0, "R12 idle rvalid low");
    rd(1'b1, 8'hFF, "R4 locked data read");
    rd(1'b0, 8'hFF, "R4 locked index read");

    // R3: broken key sequences
    wr(1'b0, 8'h87); wr(1'b0, 8'h12); wr(1'b0, 8'h87);
    chk(cfg_unlocked, 0, "R3 other index byte restarts key");
    wr(1'b0, 8'h99);
    wr(1'b0, 8'h87); wr(1'b1, 8'h00); wr(1'b0, 8'h87);
    chk(cfg_unlocked, 0, "R3 data write restarts key");
    wr(1'b1, 8'h5A); // R4 locked data write, must be ignored
    wr(1'b0, 8'h33);

    // R2: valid key
    wr(1'b0, 8'h87); wr(1'b0, 8'h87);
    chk(cfg_unlocked, 1, "R2 unlock after two keys");
    rd(1'b0, 8'h00, "R1 index latch reset value");

    // R7: write gate
    setreg(8'h22, 8'h5A);
    getreg(8'h22, 8'h00, "R7 gated write ignored");
    setreg(8'h26, 8'h40);
    getreg(8'h26, 8'h40, "R7 gate register readback");
    setreg(8'h22, 8'h5A);
    getreg(8'h22, 8'h5A, "R10 global storage readback");
    rd(1'b0, 8'h22, "R6 index port readback");
    getreg(8'h05, 8'h00, "R10 unimplemented global reads zero");

    // R8/R9/R10: device 0
    setreg(8'h07, 8'h00);
    setreg(8'h60, 8'h12); setreg(8'h61, 8'h34);
    setreg(8'h70, 8'h03); setreg(8'h71, 8'h02);
    setreg(8'h30, 8'hFF);
    chk(dev_active, 4'b0001, "R9 activate device 0");
    getreg(8'h30, 8'h01, "R9 activate reads bit 0 only");
    // device 2
    setreg(8'h07, 8'h02);
    getreg(8'h60, 8'h00, "R8 device 2 bank separate");
    setreg(8'h60, 8'hAB);
    setreg(8'h30, 8'h01);
    chk(dev_active, 4'b0101, "R9 activate device 2");
    setreg(8'hF3, 8'h9C);
    getreg(8'hF3, 8'h9C, "R10 config window readback");
    setreg(8'h40, 8'h77);
    getreg(8'h40, 8'h00, "R10 unimplemented banked reads zero");
    getreg(8'h60, 8'hAB, "R8 device 2 base high");
    setreg(8'h07, 8'h00);
    getreg(8'h60, 8'h12, "R8 device 0 base high kept");
    getreg(8'h61, 8'h34, "R10 device 0 base low");
    getreg(8'h71, 8'h02, "R10 device 0 irq type");
    getreg(8'h07, 8'h00, "R8 selector readback");

    // R11: out-of-range selector
    setreg(8'h07, 8'h09);
    getreg(8'h07, 8'h09, "R8 selector full byte");
    setreg(8'h60, 8'h55);
    getreg(8'h60, 8'h00, "R11 out-of-range read zero");
    setreg(8'h30, 8'h01);
    chk(dev_active, 4'b0101, "R11 out-of-range activate ignored");
    setreg(8'h07, 8'h01);
    getreg(8'h60, 8'h00, "R11 device 1 untouched");

    // R5: exit and retention
    setreg(8'h07, 8'h00);
    wr(1'b0, 8'h60);
    wr(1'b0, 8'hAA);
    chk(cfg_unlocked, 0, "R5 exit locks");
    chk(dev_active, 4'b0101, "R5 activate kept while locked");
    rd(1'b1, 8'hFF, "R4 read after exit");
    wr(1'b1, 8'hEE);
    wr(1'b0, 8'h87); wr(1'b0, 8'h87);
    rd(1'b0, 8'h60, "R5 index unchanged by exit");
    rd(1'b1, 8'h12, "R4 locked write ignored, R5 data kept");

    // R9: deactivate
    setreg(8'h07, 8'h02);
    setreg(8'h30, 8'h00);
    chk(dev_active, 4'b0001, "R9 deactivate device 2");

    repeat (3) @(negedge clk);
    chk(exp_q.size(), 0, "R12 every read answered");
    chk(bus_rvalid, 0, "R12 rvalid low when idle");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule